// File: doc/BRIEF.md
# Reorder Buffer Retirement and Squash Unit

This block is the in-order retirement end of a small out-of-order core. Dispatch writes one tag per cycle into a circular buffer. Each tag holds a 16-bit sequence number and a flag that marks whether the instruction must run non-speculatively, which covers serialising operations, store-conditionals and memory barriers. Writeback later reports completion by buffer index, with an optional fault. Every cycle the block walks a small window at the head. Squashed tags in that window are dropped for free. It retires up to `COMMIT_W` finished tags in program order and stops at the first tag that cannot leave yet.

Two kinds of head tag must wait for a quiet memory system: an unexecuted non-speculative tag and a faulting tag. Each is handled only when it is the first real instruction of this cycle's group and the store queue reports no committed stores still draining. A non-speculative tag then gets a one-cycle execute pulse and waits for its own completion. A faulting tag raises a trap request and waits for the flush that follows.

Squash requests carry a kind and a sequence number, and the block computes the boundary itself. Every tag younger than the boundary is marked squashed, using wrap-safe comparison, and drains out through the head. The allocate port is a valid/ready stream. Dispatch must hold `alloc_valid` and its data until it sees `alloc_ready` at a clock edge. The completion port and the commit, execute and trap outputs have no back-pressure. `DEPTH` must be a power of two.

Top module: `rob_commit`

## Requirements
- R1: Each cycle at most `COMMIT_W` tags retire on `commit_valid`/`commit_seq`, in buffer order starting at the head, with slot 0 the oldest. Valid slots are contiguous from slot 0. Retirement stops at the first non-squashed tag whose ready bit is clear.
- R2: Squashed tags inside the `SCAN_W`-entry head window are removed in the same cycle without taking a commit slot.
- R3: An unexecuted non-speculative tag at the head is released only when no tag retires ahead of it this cycle and `stores_pending` is low. Release pulses `go_valid` with its index and sequence number for one cycle. The tag then stays unretired until its completion arrives.
- R4: A completed tag with its fault bit set raises `trap_req` with `trap_seq` only when no tag retires ahead of it this cycle and `stores_pending` is low. It never retires, and the trap request lasts a single cycle.
- R5: A squash marks every valid tag whose sequence number is later than the boundary as squashed and ready. Comparison is modulo 2^16: a is later than b when a-b, read as signed, is positive.
- R6: `sq_kind` 0 (branch) uses `sq_seq` as the boundary and keeps that tag. Kind 1 (memory blocked) uses `sq_seq`-1 and removes that tag too. Kinds 2 and 3 (full flush) use head sequence minus one and remove every tag.
- R7: `irq_take` is high exactly when `irq_pending` is high, the buffer is empty and `stores_pending` is low.
- R8: In a cycle with `sq_valid` high, nothing retires, `go_valid` and `trap_req` stay low, and `alloc_ready` is low.
- R9: `alloc_ready` equals not full and not squashing. An accepted tag is written at index `alloc_idx`, which then advances by one modulo `DEPTH`.
- R10: `cmp_valid` sets the executed and ready bits of tag `cmp_idx` and records `cmp_fault`. It has no effect on an empty slot or on a squashed tag.
- R11: After reset the buffer is empty (`rob_empty` high, `rob_full` low) and no commit, execute or trap output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch offers a tag |
| alloc_ready | output | 1 | Buffer accepts the offered tag |
| alloc_seq | input | SEQ_W | Sequence number of the offered tag |
| alloc_nonspec | input | 1 | Tag must execute non-speculatively at the head |
| alloc_idx | output | IDX_W | Index the offered tag will occupy |
| cmp_valid | input | 1 | Completion report |
| cmp_idx | input | IDX_W | Index of the completed tag |
| cmp_fault | input | 1 | Completed tag faulted |
| sq_valid | input | 1 | Squash request |
| sq_kind | input | 2 | 0 branch, 1 memory blocked, 2/3 full flush |
| sq_seq | input | SEQ_W | Sequence number carried by the squash |
| stores_pending | input | 1 | Committed stores still draining |
| irq_pending | input | 1 | Interrupt waiting |
| irq_take | output | 1 | Interrupt may be accepted now |
| commit_valid | output | COMMIT_W | Per-slot retirement strobe |
| commit_seq | output | COMMIT_W*SEQ_W | Per-slot retired sequence numbers, slot 0 in the low bits |
| go_valid | output | 1 | Execute pulse for a head non-speculative tag |
| go_idx | output | IDX_W | Index of the released tag |
| go_seq | output | SEQ_W | Sequence number of the released tag |
| trap_req | output | 1 | Trap request for a faulting head tag |
| trap_seq | output | SEQ_W | Sequence number of the faulting tag |
| rob_empty | output | 1 | No tags held |
| rob_full | output | 1 | All DEPTH slots held |

## Verification
The bound checker watches the cycle-local rules on every cycle. It checks that a squash cycle blocks retirement, release, trap and allocation, and that the execute and trap pulses appear only in slot zero with the store queue quiet. It also checks that retiring slots are contiguous and in sequence order across wrap-around, that a full buffer refuses allocation, that the allocation index steps by one, that a trap pulse never repeats, and the interrupt gate. Some behaviour spans several cycles and only the bench's scenarios can show it. This covers which tags a branch, memory-blocked or flush squash keeps, that squashed tags drain without commit bandwidth, that a released tag waits for its completion, and that stray completions change nothing. The bench compares each cycle against its own model of the buffer and adds directed cases for each of these.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    SQ_BRANCH = 2'd0,
    SQ_MEMBLK = 2'd1,
    SQ_FLUSH  = 2'd2,
    SQ_FLUSH2 = 2'd3
  } sq_kind_e;

  typedef struct packed {
    logic valid;
    logic ready;
    logic exec;
    logic nonspec;
    logic fault;
    logic squashed;
  } ent_flags_t;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH  = 32,
  parameter int SCAN_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int REM_W = $clog2(SCAN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic [REM_W-1:0] retire_n,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head + IDX_W'(retire_n);
      if (alloc_fire) tail <= tail + IDX_W'(1);
      count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_n);
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/rob_entries.sv
module rob_entries import rob_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic [IDX_W-1:0] alloc_at,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic             alloc_nonspec,
  input  logic             cmp_valid,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic             cmp_fault,
  input  logic             hold_valid,
  input  logic [IDX_W-1:0] hold_idx,
  input  logic [DEPTH-1:0] retire_mask,
  input  logic             sq_fire,
  input  logic [SEQ_W-1:0] sq_bound,
  output ent_flags_t       flags [DEPTH],
  output logic [SEQ_W-1:0] seqs  [DEPTH]
);

  function automatic logic later_than(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    ent_flags_t       nxt;
    logic [SEQ_W-1:0] nxt_seq;

    always_comb begin
      nxt     = flags[e];
      nxt_seq = seqs[e];
      if (retire_mask[e]) begin
        nxt = '0;
      end else if (alloc_fire && alloc_at == IDX_W'(e)) begin
        nxt.valid    = 1'b1;
        nxt.ready    = alloc_nonspec;
        nxt.exec     = 1'b0;
        nxt.nonspec  = alloc_nonspec;
        nxt.fault    = 1'b0;
        nxt.squashed = 1'b0;
        nxt_seq      = alloc_seq;
      end else if (flags[e].valid) begin
        if (hold_valid && hold_idx == IDX_W'(e)) nxt.ready = 1'b0;
        if (cmp_valid && cmp_idx == IDX_W'(e) && !flags[e].squashed) begin
          nxt.exec  = 1'b1;
          nxt.ready = 1'b1;
          nxt.fault = cmp_fault;
        end
        if (sq_fire && later_than(seqs[e], sq_bound)) begin
          nxt.squashed = 1'b1;
          nxt.ready    = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[e] <= '0;
        seqs[e]  <= '0;
      end else begin
        flags[e] <= nxt;
        seqs[e]  <= nxt_seq;
      end
    end
  end

endmodule

// File: rtl/rob_scan.sv
module rob_scan import rob_pkg::*; #(
  parameter int DEPTH    = 32,
  parameter int COMMIT_W = 2,
  parameter int SCAN_W   = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int OFF_W = (SCAN_W > 1) ? $clog2(SCAN_W) : 1,
  localparam int REM_W = $clog2(SCAN_W + 1)
) (
  input  ent_flags_t       win   [SCAN_W],
  input  logic [CNT_W-1:0] avail,
  input  logic             stores_pending,
  input  logic             enable,
  output logic [REM_W-1:0] remove_n,
  output logic [COMMIT_W-1:0] slot_valid,
  output logic [OFF_W-1:0] slot_off [COMMIT_W],
  output logic             go_hit,
  output logic [OFF_W-1:0] go_off,
  output logic             trap_hit,
  output logic [OFF_W-1:0] trap_off
);

  always_comb begin
    int  ncom;
    int  nrem;
    logic stop;
    ncom       = 0;
    nrem       = 0;
    stop       = !enable;
    slot_valid = '0;
    for (int k = 0; k < COMMIT_W; k++) slot_off[k] = '0;
    go_hit   = 1'b0;
    go_off   = '0;
    trap_hit = 1'b0;
    trap_off = '0;
    for (int i = 0; i < SCAN_W; i++) begin
      if (!stop && (CNT_W'(i) < avail)) begin
        if (win[i].squashed) begin
          nrem = nrem + 1;
        end else if (!win[i].ready) begin
          stop = 1'b1;
        end else if (win[i].fault) begin
          if (ncom == 0 && !stores_pending) begin
            trap_hit = 1'b1;
            trap_off = OFF_W'(i);
          end
          stop = 1'b1;
        end else if (!win[i].exec) begin
          if (ncom == 0 && !stores_pending) begin
            go_hit = 1'b1;
            go_off = OFF_W'(i);
          end
          stop = 1'b1;
        end else if (ncom < COMMIT_W) begin
          slot_valid[ncom] = 1'b1;
          slot_off[ncom]   = OFF_W'(i);
          ncom = ncom + 1;
          nrem = nrem + 1;
        end else begin
          stop = 1'b1;
        end
      end else begin
        stop = 1'b1;
      end
    end
    remove_n = REM_W'(nrem);
  end

endmodule

// File: rtl/rob_commit.sv
module rob_commit import rob_pkg::*; #(
  parameter int DEPTH    = 32,
  parameter int COMMIT_W = 2,
  parameter int SCAN_W   = 4,
  parameter int SEQ_W    = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int OFF_W = (SCAN_W > 1) ? $clog2(SCAN_W) : 1,
  localparam int REM_W = $clog2(SCAN_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  output logic                      alloc_ready,
  input  logic [SEQ_W-1:0]          alloc_seq,
  input  logic                      alloc_nonspec,
  output logic [IDX_W-1:0]          alloc_idx,
  input  logic                      cmp_valid,
  input  logic [IDX_W-1:0]          cmp_idx,
  input  logic                      cmp_fault,
  input  logic                      sq_valid,
  input  logic [1:0]                sq_kind,
  input  logic [SEQ_W-1:0]          sq_seq,
  input  logic                      stores_pending,
  input  logic                      irq_pending,
  output logic                      irq_take,
  output logic [COMMIT_W-1:0]       commit_valid,
  output logic [COMMIT_W*SEQ_W-1:0] commit_seq,
  output logic                      go_valid,
  output logic [IDX_W-1:0]          go_idx,
  output logic [SEQ_W-1:0]          go_seq,
  output logic                      trap_req,
  output logic [SEQ_W-1:0]          trap_seq,
  output logic                      rob_empty,
  output logic                      rob_full
);

  ent_flags_t       flags [DEPTH];
  logic [SEQ_W-1:0] seqs  [DEPTH];
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             alloc_fire;
  logic [REM_W-1:0] remove_n;
  logic [DEPTH-1:0] retire_mask;
  logic [IDX_W-1:0] w_pos [SCAN_W];
  ent_flags_t       w_flags [SCAN_W];
  logic [COMMIT_W-1:0] slot_valid;
  logic [OFF_W-1:0] slot_off [COMMIT_W];
  logic             go_hit, trap_hit;
  logic [OFF_W-1:0] go_off, trap_off;
  logic             hold_valid;
  logic [IDX_W-1:0] hold_idx;
  logic [SEQ_W-1:0] sq_bound;

  assign alloc_ready = !rob_full && !sq_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail;

  rob_ptrs #(.DEPTH(DEPTH), .SCAN_W(SCAN_W)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .retire_n   (remove_n),
    .head       (head),
    .tail       (tail),
    .count      (count),
    .full       (rob_full),
    .empty      (rob_empty)
  );

  for (genvar i = 0; i < SCAN_W; i++) begin : g_win
    assign w_pos[i]   = head + IDX_W'(i);
    assign w_flags[i] = flags[w_pos[i]];
  end

  rob_scan #(.DEPTH(DEPTH), .COMMIT_W(COMMIT_W), .SCAN_W(SCAN_W)) u_scan (
    .win            (w_flags),
    .avail          (count),
    .stores_pending (stores_pending),
    .enable         (!sq_valid),
    .remove_n       (remove_n),
    .slot_valid     (slot_valid),
    .slot_off       (slot_off),
    .go_hit         (go_hit),
    .go_off         (go_off),
    .trap_hit       (trap_hit),
    .trap_off       (trap_off)
  );

  always_comb begin
    retire_mask = '0;
    for (int i = 0; i < SCAN_W; i++)
      if (REM_W'(i) < remove_n) retire_mask[w_pos[i]] = 1'b1;
  end

  always_comb begin
    case (sq_kind_e'(sq_kind))
      SQ_BRANCH: sq_bound = sq_seq;
      SQ_MEMBLK: sq_bound = sq_seq - SEQ_W'(1);
      default:   sq_bound = seqs[head] - SEQ_W'(1);
    endcase
  end

  assign hold_valid = go_hit || trap_hit;
  assign hold_idx   = go_hit ? w_pos[go_off] : w_pos[trap_off];

  rob_entries #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_ent (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_fire    (alloc_fire),
    .alloc_at      (tail),
    .alloc_seq     (alloc_seq),
    .alloc_nonspec (alloc_nonspec),
    .cmp_valid     (cmp_valid),
    .cmp_idx       (cmp_idx),
    .cmp_fault     (cmp_fault),
    .hold_valid    (hold_valid),
    .hold_idx      (hold_idx),
    .retire_mask   (retire_mask),
    .sq_fire       (sq_valid),
    .sq_bound      (sq_bound),
    .flags         (flags),
    .seqs          (seqs)
  );

  for (genvar k = 0; k < COMMIT_W; k++) begin : g_out
    assign commit_valid[k] = slot_valid[k];
    assign commit_seq[k*SEQ_W +: SEQ_W] = seqs[w_pos[slot_off[k]]];
  end

  assign go_valid = go_hit;
  assign go_idx   = w_pos[go_off];
  assign go_seq   = seqs[go_idx];
  assign trap_req = trap_hit;
  assign trap_seq = seqs[w_pos[trap_off]];
  assign irq_take = irq_pending && rob_empty && !stores_pending;

endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
  parameter int DEPTH    = 32,
  parameter int COMMIT_W = 2,
  parameter int SEQ_W    = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      alloc_valid,
  input logic                      alloc_ready,
  input logic [IDX_W-1:0]          alloc_idx,
  input logic                      sq_valid,
  input logic                      stores_pending,
  input logic                      irq_pending,
  input logic                      irq_take,
  input logic [COMMIT_W-1:0]       commit_valid,
  input logic [COMMIT_W*SEQ_W-1:0] commit_seq,
  input logic                      go_valid,
  input logic                      trap_req,
  input logic                      rob_empty,
  input logic                      rob_full
);

  function automatic logic later_than(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction

  assert_squash_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> (commit_valid == '0 && !go_valid && !trap_req && !alloc_ready));

  assert_no_alloc_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rob_full |-> !alloc_ready);

  assert_alloc_idx_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_idx == IDX_W'($past(alloc_idx) + 1'b1)));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_pending && rob_empty && !stores_pending));

  assert_go_slot_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid |-> (commit_valid == '0 && !stores_pending && !trap_req));

  assert_trap_slot_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (commit_valid == '0 && !stores_pending));

  assert_trap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req);

  assert_empty_full_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rob_empty && rob_full));

  for (genvar k = 1; k < COMMIT_W; k++) begin : g_ord
    assert_commit_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid[k] |-> (commit_valid[k-1] &&
        later_than(commit_seq[k*SEQ_W +: SEQ_W], commit_seq[(k-1)*SEQ_W +: SEQ_W])));
  end

endmodule

bind rob_commit rob_commit_chk #(.DEPTH(DEPTH), .COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/rob_commit_tb.sv
`timescale 1ns/100ps
module rob_commit_tb;
  localparam int DEPTH = 32, CW = 2, SW = 4, QW = 16;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic a_valid = 0, a_ns = 0, c_valid = 0, c_fault = 0, s_valid = 0, sp = 0, irq = 0;
  logic [QW-1:0] a_seq = '0, s_seq = '0;
  logic [IW-1:0] c_idx = '0;
  logic [1:0]    s_kind = '0;

  logic alloc_ready, irq_take, go_valid, trap_req, rob_empty, rob_full;
  logic [IW-1:0] alloc_idx, go_idx;
  logic [CW-1:0] commit_valid;
  logic [CW*QW-1:0] commit_seq;
  logic [QW-1:0] go_seq, trap_seq;

  rob_commit #(.DEPTH(DEPTH), .COMMIT_W(CW), .SCAN_W(SW), .SEQ_W(QW)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(a_valid), .alloc_ready(alloc_ready),
    .alloc_seq(a_seq), .alloc_nonspec(a_ns), .alloc_idx(alloc_idx),
    .cmp_valid(c_valid), .cmp_idx(c_idx), .cmp_fault(c_fault),
    .sq_valid(s_valid), .sq_kind(s_kind), .sq_seq(s_seq),
    .stores_pending(sp), .irq_pending(irq), .irq_take(irq_take),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .go_valid(go_valid), .go_idx(go_idx), .go_seq(go_seq),
    .trap_req(trap_req), .trap_seq(trap_seq),
    .rob_empty(rob_empty), .rob_full(rob_full));

  int total = 0, bad = 0;
  bit done = 0;

  // bench model of the buffer
  bit mv[DEPTH], mr[DEPTH], me[DEPTH], mn[DEPTH], mf[DEPTH], ms[DEPTH];
  logic [QW-1:0] mq[DEPTH];
  int mhead = 0, mtail = 0, mcount = 0;
  // expected outputs
  bit e_cv[CW]; logic [QW-1:0] e_cs[CW];
  bit e_go, e_trap, e_fire; int e_hold, e_rem;
  logic [QW-1:0] e_go_seq, e_trap_seq;
  bit settled = 0;

  function automatic bit later(input logic [QW-1:0] a, input logic [QW-1:0] b);
    return $signed(QW'(a - b)) > 0;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic predict();
    int ncom = 0; bit stop = s_valid;
    e_rem = 0; e_go = 0; e_trap = 0; e_hold = -1;
    for (int k = 0; k < CW; k++) begin e_cv[k] = 0; e_cs[k] = '0; end
    for (int i = 0; i < SW; i++) begin
      int p = (mhead + i) % DEPTH;
      if (stop || i >= mcount) stop = 1;
      else if (ms[p]) e_rem++;
      else if (!mr[p]) stop = 1;
      else if (mf[p]) begin
        if (ncom == 0 && !sp) begin e_trap = 1; e_trap_seq = mq[p]; e_hold = p; end
        stop = 1;
      end else if (!me[p]) begin
        if (ncom == 0 && !sp) begin e_go = 1; e_go_seq = mq[p]; e_hold = p; end
        stop = 1;
      end else if (ncom < CW) begin
        e_cv[ncom] = 1; e_cs[ncom] = mq[p]; ncom++; e_rem++;
      end else stop = 1;
    end
    e_fire = a_valid && (mcount < DEPTH) && !s_valid;
  endtask

  task automatic update();
    logic [QW-1:0] bnd;
    if (e_hold >= 0) mr[e_hold] = 0;
    if (c_valid && mv[c_idx] && !ms[c_idx]) begin me[c_idx] = 1; mr[c_idx] = 1; mf[c_idx] = c_fault; end
    if (s_valid) begin
      bnd = (s_kind == 0) ? s_seq : (s_kind == 1) ? QW'(s_seq - 1) : QW'(mq[mhead] - 1);
      for (int e = 0; e < DEPTH; e++)
        if (mv[e] && later(mq[e], bnd)) begin ms[e] = 1; mr[e] = 1; end
    end
    for (int i = 0; i < e_rem; i++) begin
      int p = (mhead + i) % DEPTH;
      mv[p] = 0; mr[p] = 0; me[p] = 0; mn[p] = 0; mf[p] = 0; ms[p] = 0;
    end
    mhead = (mhead + e_rem) % DEPTH; mcount -= e_rem;
    if (e_fire) begin
      mv[mtail] = 1; mr[mtail] = a_ns; me[mtail] = 0; mn[mtail] = a_ns; mf[mtail] = 0; ms[mtail] = 0;
      mq[mtail] = a_seq; mtail = (mtail + 1) % DEPTH; mcount++;
    end
  endtask

  task automatic settle();
    #1; settled = 1; predict();
  endtask

  task automatic step();
    if (!settled) settle();
    for (int k = 0; k < CW; k++) begin
      chk("R1", "commit_valid", commit_valid[k], e_cv[k]);
      if (e_cv[k]) chk("R1", "commit_seq", commit_seq[k*QW +: QW], e_cs[k]);
    end
    chk("R3", "go_valid", go_valid, e_go);
    if (e_go) chk("R3", "go_seq", go_seq, e_go_seq);
    chk("R4", "trap_req", trap_req, e_trap);
    if (e_trap) chk("R4", "trap_seq", trap_seq, e_trap_seq);
    chk("R7", "irq_take", irq_take, irq && mcount == 0 && !sp);
    chk("R9", "alloc_ready", alloc_ready, (mcount < DEPTH) && !s_valid);
    if (e_fire) chk("R9", "alloc_idx", alloc_idx, mtail);
    chk("R11", "rob_empty", rob_empty, mcount == 0);
    chk("R11", "rob_full", rob_full, mcount == DEPTH);
    update();
    @(negedge clk);
    settled = 0;
  endtask

  task automatic quiet();
    a_valid = 0; c_valid = 0; c_fault = 0; s_valid = 0; s_kind = 0;
  endtask

  task automatic put(input logic [QW-1:0] q, input bit ns);
    quiet(); a_valid = 1; a_seq = q; a_ns = ns; step();
  endtask

  task automatic cmp(input int idx, input bit flt);
    quiet(); c_valid = 1; c_idx = IW'(idx); c_fault = flt; step();
  endtask

  task automatic flush_all();
    quiet(); s_valid = 1; s_kind = 2; step();
    quiet(); for (int n = 0; n < DEPTH / SW + 2; n++) step();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic [QW-1:0] nseq;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state
    settle();
    chk("R11", "empty after reset", rob_empty, 1);
    chk("R11", "commit after reset", commit_valid, 0);
    chk("R11", "go/trap after reset", {go_valid, trap_req}, 0);
    step();

    // R9: fill to the top, allocation refused
    for (int n = 0; n < DEPTH; n++) put(QW'(16'h0100 + n), 0);
    quiet(); a_valid = 1; a_seq = 16'h0200; settle();
    chk("R9", "ready while full", alloc_ready, 0);
    chk("R9", "full flag", rob_full, 1);
    step();
    flush_all();
    settle(); chk("R6", "flush empties buffer", rob_empty, 1); step();

    // R1/R2/R5/R6: branch squash keeps branch, drains younger
    base = mtail;
    for (int n = 0; n < 4; n++) put(QW'(10 + n), 0);
    cmp((base + 3) % DEPTH, 0);
    cmp((base + 2) % DEPTH, 0);
    cmp((base + 1) % DEPTH, 0);
    settle(); chk("R1", "head not ready blocks", commit_valid, 0); step();
    quiet(); c_valid = 1; c_idx = IW'(base); s_valid = 1; s_kind = 0; s_seq = 16'd11;
    settle(); chk("R8", "no commit in squash cycle", commit_valid, 0); step();
    quiet(); settle();
    chk("R5", "two oldest retire", commit_valid, 2'b11);
    chk("R6", "branch kept", commit_seq[QW +: QW], 16'd11);
    step();
    settle(); chk("R2", "squashed drained free", rob_empty, 1); step();

    // R6: memory-blocked squash removes the load
    base = mtail;
    for (int n = 0; n < 3; n++) put(QW'(20 + n), 0);
    cmp((base + 2) % DEPTH, 0);
    cmp((base + 1) % DEPTH, 0);
    quiet(); c_valid = 1; c_idx = IW'(base); s_valid = 1; s_kind = 1; s_seq = 16'd21; step();
    quiet(); settle();
    chk("R6", "only older than load retires", commit_valid, 2'b01);
    chk("R6", "retired seq", commit_seq[QW-1:0], 16'd20);
    step();
    settle(); chk("R5", "load and younger gone", rob_empty, 1); step();

    // R3/R10: non-speculative tag behind a normal one
    base = mtail;
    put(16'd30, 0);
    put(16'd31, 1);
    quiet(); c_valid = 1; c_idx = IW'(base); settle();
    chk("R3", "not slot zero, no go", go_valid, 0); step();
    quiet(); sp = 1; settle(); chk("R3", "stores pending, no go", go_valid, 0); step();
    sp = 0; settle();
    chk("R3", "go pulse", go_valid, 1);
    chk("R3", "go idx", go_idx, (base + 1) % DEPTH);
    step();
    quiet(); c_valid = 1; c_idx = IW'((base + 5) % DEPTH); settle();
    chk("R3", "released tag waits", {go_valid, commit_valid}, 0); step();
    quiet(); settle(); chk("R10", "stray completion ignored", commit_valid, 0); step();
    cmp((base + 1) % DEPTH, 0);
    quiet(); settle(); chk("R3", "commits after completion", commit_valid, 2'b01); step();

    // R4: fault waits for quiet stores, traps once
    base = mtail;
    put(16'd40, 0);
    quiet(); sp = 1; c_valid = 1; c_idx = IW'(base); c_fault = 1; step();
    quiet(); settle(); chk("R4", "no trap while stores pending", trap_req, 0); step();
    sp = 0; settle(); chk("R4", "trap raised", trap_req, 1); chk("R4", "trap seq", trap_seq, 16'd40); step();
    settle(); chk("R4", "trap not repeated", {trap_req, commit_valid}, 0); step();
    flush_all();

    // R7: interrupt gate
    quiet(); irq = 1; sp = 1; settle(); chk("R7", "irq blocked by stores", irq_take, 0); step();
    sp = 0; settle(); chk("R7", "irq taken when idle", irq_take, 1); step();
    irq = 0;

    // random phase across sequence wrap-around
    nseq = 16'hFFC0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit tr_prev;
      tr_prev = e_trap;
      quiet();
      a_valid = ($urandom % 10) < 6; a_seq = nseq; a_ns = ($urandom % 8) == 0;
      c_idx = IW'($urandom % DEPTH);
      if (($urandom % 10) < 7)
        for (int j = 0; j < DEPTH; j++) begin
          int p = (mhead + j) % DEPTH;
          if (j < mcount && !me[p] && !ms[p] && ($urandom % 3) == 0) begin c_idx = IW'(p); break; end
        end
      c_valid = ($urandom % 4) != 0;
      c_fault = ($urandom % 30) == 0;
      sp = ($urandom % 4) == 0;
      irq = ($urandom % 3) == 0;
      if (tr_prev || ($urandom % 40) == 0) begin
        s_valid = 1;
        s_kind = tr_prev ? 2'd2 : 2'($urandom % 4);
        s_seq = mq[(mhead + ($urandom % (mcount > 0 ? mcount : 1))) % DEPTH];
      end
      settle();
      if (e_fire) nseq = nseq + 1;
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule